// File: doc/BRIEF.md
# Packed Decimal Ripple Adder

This block adds two unsigned decimal numbers held in packed BCD form, four bits per decimal digit, together with a one-bit carry-in. The number of digits is a parameter (default four). The block is purely combinational: the sum and the decimal carry-out settle from the operands with no clock.

Each digit is handled by its own slice, and the slices are chained from the least significant digit to the most significant. A slice first forms the plain binary sum of its two digits and its incoming carry, a value from 0 to 19. If that value is above nine, the slice adds 0110 to the low four bits, drops the carry of that second addition, and raises a decimal carry into the next slice. The carry of the top slice is the block's carry-out. Operands with digit codes 1010 to 1111 are outside the block's contract, and the block does not subtract.

Top module: `bcd_ripple_adder`

## Requirements
- R1: A decimal digit d (0 to 9) is coded as the 4-bit binary value of d, and digit k of a packed word sits in bits [4k+3:4k]. With both operands zero and carry-in 0, the sum is zero and the carry-out is 0.
- R2: Each slice forms the binary sum of its two digits and its carry-in. When that sum is at most nine, the output digit equals it. When the sum exceeds nine, the output digit is the low four bits of that sum plus 0110.
- R3: For legal operand digits, every output digit lies in 0000 to 1001.
- R4: The decimal carry of a slice is 1 exactly when its binary digit sum exceeds nine. This covers a carry out of the 4-bit add and low-four-bit patterns 11XX or 1X1X.
- R5: 5 + 8 with carry-in 0 gives digit 0011 and a decimal carry of 1.
- R6: 9 + 7 with carry-in 0 gives digit 0110 and a decimal carry of 1.
- R7: The external carry-in enters digit 0. Each slice's decimal carry is the carry-in of the next higher digit, and the top slice's carry becomes the carry-out.
- R8: For any legal operands, value(A) + value(B) + carry_in equals carry_out * 10^N plus value(sum), where N is the digit count.
- R9: An all-nines operand plus zero with carry-in 1 gives an all-zero sum and a carry-out of 1, with the carry passing through every slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4*N_DIGITS | First packed BCD operand |
| opnd_b | input | 4*N_DIGITS | Second packed BCD operand |
| carry_in | input | 1 | Decimal carry into digit 0 |
| sum_bcd | output | 4*N_DIGITS | Packed BCD sum |
| carry_out | output | 1 | Decimal carry out of the top digit |

## Verification
The case that is hardest to reach from the ports is an upper slice whose carry-in is 1 while its own digits already sum to nine or more. Only a carry produced by the digit below can set that carry-in. The bench places every single-digit pair, at both carry values, into digit 2. It then sets digits 1 and 0 of the operands so that they either do or do not carry into digit 2. A chain of all-nines digits with carry-in 1 drives a carry through every slice.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    localparam bcd_digit_t DIGIT_MAX = 4'd9;
    localparam bcd_digit_t FIX_CONST = 4'b0110;

    // Binary digit sum above nine: 4-bit carry, or 11XX, or 1X1X.
    function automatic logic over_nine(input logic bin_co, input bcd_digit_t s);
        return bin_co | (s[3] & s[2]) | (s[3] & s[1]);
    endfunction

endpackage

// File: rtl/bcd_digit_sum.sv
module bcd_digit_sum
    import bcd_add_pkg::*;
(
    input  bcd_digit_t dig_a,
    input  bcd_digit_t dig_b,
    input  logic       cin,
    output bcd_digit_t bin_sum,
    output logic       bin_co
);
    logic [DIGIT_W:0] c;

    assign c[0] = cin;

    genvar i;
    generate
        for (i = 0; i < DIGIT_W; i++) begin : g_fa
            logic p;
            assign p          = dig_a[i] ^ dig_b[i];
            assign bin_sum[i] = p ^ c[i];
            assign c[i+1]     = (dig_a[i] & dig_b[i]) | (p & c[i]);
        end
    endgenerate

    assign bin_co = c[DIGIT_W];
endmodule

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix
    import bcd_add_pkg::*;
(
    input  bcd_digit_t bin_sum,
    input  logic       bin_co,
    output bcd_digit_t dig_out,
    output logic       dec_co
);
    bcd_digit_t addend;

    always_comb begin
        dec_co  = over_nine(bin_co, bin_sum);
        addend  = dec_co ? FIX_CONST : '0;
        // 4-bit result: the correction add's own carry is dropped
        dig_out = bin_sum + addend;
    end
endmodule

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
    import bcd_add_pkg::*;
(
    input  bcd_digit_t dig_a,
    input  bcd_digit_t dig_b,
    input  logic       cin,
    output bcd_digit_t dig_out,
    output logic       cout
);
    bcd_digit_t bin_sum;
    logic       bin_co;

    bcd_digit_sum u_sum (
        .dig_a   (dig_a),
        .dig_b   (dig_b),
        .cin     (cin),
        .bin_sum (bin_sum),
        .bin_co  (bin_co)
    );

    bcd_digit_fix u_fix (
        .bin_sum (bin_sum),
        .bin_co  (bin_co),
        .dig_out (dig_out),
        .dec_co  (cout)
    );

    // Independent arithmetic view of the slice, used only by the checks
    logic [DIGIT_W:0] ref_raw;
    logic             legal_in;
    assign ref_raw  = {1'b0, dig_a} + {1'b0, dig_b} + {{DIGIT_W{1'b0}}, cin};
    assign legal_in = (dig_a <= DIGIT_MAX) && (dig_b <= DIGIT_MAX);

    always_comb begin
        if (!$isunknown({dig_a, dig_b, cin, dig_out, cout}) && legal_in) begin
            p_sum_path_r2: assert (ref_raw > 5'd9 || (dig_out == ref_raw[DIGIT_W-1:0]))
                else $error("slice: uncorrected digit wrong");
            p_fix_path_r2: assert (ref_raw <= 5'd9 || ({1'b0, dig_out} == ref_raw - 5'd10))
                else $error("slice: corrected digit wrong");
            p_carry_r4: assert (cout == (ref_raw > 5'd9))
                else $error("slice: decimal carry wrong");
            p_digit_legal_r3: assert (dig_out <= DIGIT_MAX)
                else $error("slice: output digit not decimal");
        end
    end
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder
    import bcd_add_pkg::*;
#(
    parameter int N_DIGITS = 4
) (
    input  logic [4*N_DIGITS-1:0] opnd_a,
    input  logic [4*N_DIGITS-1:0] opnd_b,
    input  logic                  carry_in,
    output logic [4*N_DIGITS-1:0] sum_bcd,
    output logic                  carry_out
);
    localparam int WORD_W = DIGIT_W * N_DIGITS;

    logic [N_DIGITS:0] chain;

    assign chain[0] = carry_in;

    genvar k;
    generate
        for (k = 0; k < N_DIGITS; k++) begin : g_slice
            bcd_digit_slice u_slice (
                .dig_a   (opnd_a[DIGIT_W*k +: DIGIT_W]),
                .dig_b   (opnd_b[DIGIT_W*k +: DIGIT_W]),
                .cin     (chain[k]),
                .dig_out (sum_bcd[DIGIT_W*k +: DIGIT_W]),
                .cout    (chain[k+1])
            );
        end
    endgenerate

    assign carry_out = chain[N_DIGITS];

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, carry_in, sum_bcd, carry_out})) begin
            // Zero operands: only the external carry may appear, in digit 0 (R7)
            p_ripple_entry_r7: assert (!(opnd_a == '0 && opnd_b == '0) ||
                                       (sum_bcd == WORD_W'(carry_in) && !carry_out))
                else $error("top: carry-in not applied at digit 0");
        end
    end
endmodule

// File: tb/bcd_ripple_adder_tb.sv
module bcd_ripple_adder_tb;
    localparam int ND = 4;
    localparam int W  = 4 * ND;
    localparam int MODV = 10000;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, s;
    logic         ci, co;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done  = 0;

    always #5 clk = ~clk;

    bcd_ripple_adder #(.N_DIGITS(ND)) u_dut (
        .opnd_a    (a),
        .opnd_b    (b),
        .carry_in  (ci),
        .sum_bcd   (s),
        .carry_out (co)
    );

    function automatic int from_bcd(input logic [W-1:0] v);
        int r = 0;
        for (int k = ND - 1; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
        return r;
    endfunction

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r = '0;
        int t = v;
        for (int k = 0; k < ND; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string tag);
        int total;
        logic [W-1:0] es;
        logic ec;
        @(negedge clk);
        a = va; b = vb; ci = vc;
        @(posedge clk);
        #2;
        total = from_bcd(va) + from_bcd(vb) + int'(vc);
        es = to_bcd(total % MODV);
        ec = (total >= MODV);
        n_vec++;
        if (s !== es || co !== ec) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h ci=%b got sum=%h co=%b expected sum=%h co=%b",
                     tag, va, vb, vc, s, co, es, ec);
        end
        for (int k = 0; k < ND; k++) begin
            if (s[4*k +: 4] > 4'd9) begin
                n_bad++;
                $display("FAIL R3: digit %0d got %h expected <= 9", k, s[4*k +: 4]);
            end
        end
    endtask

    initial begin
        int seed = 12345;
        a = '0; b = '0; ci = 1'b0;

        // R1: zero operands
        apply('0, '0, 1'b0, "R1");
        // R5, R6: worked digit examples
        apply(to_bcd(5), to_bcd(8), 1'b0, "R5");
        apply(to_bcd(9), to_bcd(7), 1'b0, "R6");
        // R9: carry through every slice
        apply(to_bcd(9999), '0, 1'b1, "R9");
        apply('0, to_bcd(9999), 1'b1, "R9");
        apply(to_bcd(9999), to_bcd(9999), 1'b1, "R9");

        // R2/R4: every digit pair at digit 0, both carry-in values
        for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
                for (int c = 0; c < 2; c++)
                    apply(to_bcd(x), to_bcd(y), c[0],
                          (x + y + c > 9) ? "R4" : "R2");

        // R7: pairs at digit 2, with digits 1..0 carrying in or not
        for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
                for (int c = 0; c < 2; c++)
                    apply(to_bcd(x * 100 + (c == 1 ? 99 : 45)),
                          to_bcd(y * 100 + (c == 1 ? 1 : 12)),
                          1'b0, "R7");

        // R8: pseudo-random full-width operands
        for (int i = 0; i < 400; i++) begin
            int va, vb;
            seed = seed * 1103515245 + 12345;
            va = ((seed >>> 8) & 32'h7fff_ffff) % MODV;
            seed = seed * 1103515245 + 12345;
            vb = ((seed >>> 8) & 32'h7fff_ffff) % MODV;
            apply(to_bcd(va), to_bcd(vb), seed[20], "R8");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule